// File: doc/BRIEF.md
# Polyphase x8 Root-Raised-Cosine Interpolator

This block shapes one rail of a QPSK baseband stream. Each accepted input is a single symbol sign. For every symbol the block produces eight signed output samples, so the output rate is eight times the baud rate. The filter has 64 taps and uses a root-raised-cosine response with roll-off 0.5. It is split into 8 polyphase branches of 8 taps each. A sign input only selects whether a coefficient is added or subtracted, so the datapath needs no multipliers. The I rail and the Q rail each use one instance with the same coefficients.

Symbols enter through a valid/ready handshake and samples leave through another. The output register holds one sample. It refills only when that register is empty or when the consumer takes the sample in the same cycle. When a consumer stalls, the sample and its valid flag stay frozen, and the input stalls too, because new symbols are accepted only at the start of a symbol period. A new symbol is taken only when `burst_en` is high. When `burst_en` is low, the block keeps producing samples but shifts zeros into the delay line, so the output decays to mid-scale. A plain `bypass` input replaces the filter with a fixed full-scale level that follows the newest symbol, for test.

Top module: `rrc_interp8`

## Requirements
- R1: Each symbol in the delay line yields exactly `L`=8 output samples. The symbol enters with the phase-0 sample, and `s_ready` can be high only when the next sample to be produced is phase 0.
- R2: A sample is produced only when the output register is empty or is being emptied (`!m_valid || m_ready`).
  - With bypass off, the sample for phase k equals the sum, over n = 0..7, of c[8n+k]·x[n].
  - x[0] is the newest symbol. A symbol with `s_sign`=0 counts as +1, one with `s_sign`=1 counts as −1, and an empty or zero slot counts as 0.
  - Coefficient i is the signed `CW`-bit field at bits [i·CW +: CW] of `TAPS`.
- R3: The sum is rounded by adding 2^(SHIFT−1) and then arithmetically shifting right by `SHIFT`. The result is saturated to the range [−256, 255] of the 9-bit output.
- R4: With `bypass` high, every sample is +FULL (255) when the newest slot holds `s_sign`=0, −FULL when it holds `s_sign`=1, and 0 when that slot is zero.
- R5: While `burst_en` is low, `s_ready` stays low and a zero is shifted in at each phase 0. Eight such symbol periods bring the output to exactly 0.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` stays high and `m_sample` keeps its value.
- R7: After reset, `m_valid` is low, the delay line is all zero, and the next sample is phase 0.
- R8: With `burst_en` high, at phase 0 the block waits for `s_valid`. During that wait it produces no sample, and `m_valid` drops once the held sample is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bypass | input | 1 | Test mode: output full-scale sign levels instead of filtered samples |
| burst_en | input | 1 | High inside a burst: take symbols. Low: shift zeros |
| s_valid | input | 1 | Symbol offered |
| s_ready | output | 1 | Symbol accepted when high together with `s_valid` |
| s_sign | input | 1 | Symbol sign: 0 means +1, 1 means −1 |
| m_valid | output | 1 | Output sample valid |
| m_ready | input | 1 | Consumer takes the sample |
| m_sample | output | OW (9) | Signed two's complement output sample |

## Verification
The assertions check the output handshake rules on every cycle:
- a stalled sample and its valid flag stay frozen;
- `s_ready` never rises outside a burst;
- any sample loaded while bypass is on is one of the three allowed levels.

Only the bench's cycle-accurate reference model can show the rest:
- the numeric correctness of the polyphase sums;
- the rounding and saturation edges;
- the eight-samples-per-symbol cadence under random stalls;
- the decay to zero after a burst.

// File: rtl/rrc_interp_pkg.sv
package rrc_interp_pkg;

  typedef struct packed {
    logic live;  // slot holds a real symbol
    logic neg;   // symbol is -1
  } slot_t;

  localparam int DEF_NTAPS = 64;
  localparam int DEF_CW    = 12;

  // Symmetric placeholder response; real RRC values are given per instance.
  function automatic logic [DEF_NTAPS*DEF_CW-1:0] default_taps();
    logic [DEF_NTAPS*DEF_CW-1:0] v;
    v = '0;
    for (int i = 0; i < DEF_NTAPS; i++) begin
      int c;
      c = (i < DEF_NTAPS / 2) ? (i + 1) * 16 : (DEF_NTAPS - i) * 16;
      v[i*DEF_CW +: DEF_CW] = DEF_CW'(c);
    end
    return v;
  endfunction

endpackage

// File: rtl/rrc_sym_line.sv
module rrc_sym_line
  import rrc_interp_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  shift,
  input  slot_t ins,
  output slot_t view [DEPTH]
);

  slot_t q [DEPTH];

  // view shows the line as it will be after this cycle's shift
  always_comb begin
    view[0] = shift ? ins : q[0];
    for (int i = 1; i < DEPTH; i++) begin
      view[i] = shift ? q[i-1] : q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= '0;
    end else if (shift) begin
      for (int i = 0; i < DEPTH; i++) q[i] <= view[i];
    end
  end

endmodule

// File: rtl/rrc_phase_sum.sv
module rrc_phase_sum
  import rrc_interp_pkg::*;
#(
  parameter int L       = 8,
  parameter int PH_TAPS = 8,
  parameter int CW      = 12,
  parameter logic [L*PH_TAPS*CW-1:0] TAPS = '0,
  localparam int PW = (L > 1) ? $clog2(L) : 1,
  localparam int AW = CW + $clog2(PH_TAPS) + 1
) (
  input  logic [PW-1:0]        phase,
  input  slot_t                line [PH_TAPS],
  output logic signed [AW-1:0] acc
);

  logic [PH_TAPS-1:0][CW-1:0] coef_sel;

  for (genvar n = 0; n < PH_TAPS; n++) begin : g_tap
    assign coef_sel[n] = TAPS[(n*L + int'(phase))*CW +: CW];
  end

  always_comb begin
    acc = '0;
    for (int n = 0; n < PH_TAPS; n++) begin
      if (line[n].live) begin
        if (line[n].neg) acc = acc - AW'($signed(coef_sel[n]));
        else             acc = acc + AW'($signed(coef_sel[n]));
      end
    end
  end

endmodule

// File: rtl/rrc_round_sat.sv
module rrc_round_sat #(
  parameter int AW    = 16,
  parameter int OW    = 9,
  parameter int SHIFT = 3
) (
  input  logic signed [AW-1:0] acc,
  output logic signed [OW-1:0] sample
);

  localparam int BW = AW + 1;
  localparam logic signed [BW-1:0] HALF = BW'(1 <<< (SHIFT - 1));
  localparam logic signed [BW-1:0] MAXV = BW'((1 <<< (OW - 1)) - 1);
  localparam logic signed [BW-1:0] MINV = -BW'(1 <<< (OW - 1));

  logic signed [BW-1:0] biased;
  logic signed [BW-1:0] scaled;

  always_comb begin
    biased = BW'(acc) + HALF;
    scaled = biased >>> SHIFT;
    if (scaled > MAXV)      sample = MAXV[OW-1:0];
    else if (scaled < MINV) sample = MINV[OW-1:0];
    else                    sample = scaled[OW-1:0];
  end

endmodule

// File: rtl/rrc_interp8.sv
module rrc_interp8
  import rrc_interp_pkg::*;
#(
  parameter int L       = 8,
  parameter int PH_TAPS = 8,
  parameter int CW      = 12,
  parameter int OW      = 9,
  parameter int SHIFT   = 3,
  parameter int FULL    = 255,
  parameter logic [L*PH_TAPS*CW-1:0] TAPS = rrc_interp_pkg::default_taps()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass,
  input  logic          burst_en,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          s_sign,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [OW-1:0] m_sample
);

  localparam int PW = (L > 1) ? $clog2(L) : 1;
  localparam int AW = CW + $clog2(PH_TAPS) + 1;
  localparam logic [PW-1:0] LAST_PH = PW'(L - 1);
  localparam logic [OW-1:0] FULL_P  = OW'(FULL);

  logic [PW-1:0]        ph_q;
  logic                 mv_q;
  logic [OW-1:0]        samp_q;
  logic                 at_sym, out_free, fire, shift;
  slot_t                ins;
  slot_t                view [PH_TAPS];
  logic signed [AW-1:0] acc;
  logic signed [OW-1:0] filt;
  logic [OW-1:0]        byp, next_samp;

  assign at_sym   = (ph_q == '0);
  assign out_free = !mv_q || m_ready;
  assign fire     = out_free && (!at_sym || !burst_en || s_valid);
  assign shift    = fire && at_sym;
  assign s_ready  = out_free && at_sym && burst_en;
  assign ins      = burst_en ? '{live: 1'b1, neg: s_sign} : '0;

  rrc_sym_line #(.DEPTH(PH_TAPS)) u_line (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (shift),
    .ins   (ins),
    .view  (view)
  );

  rrc_phase_sum #(
    .L(L), .PH_TAPS(PH_TAPS), .CW(CW), .TAPS(TAPS)
  ) u_sum (
    .phase (ph_q),
    .line  (view),
    .acc   (acc)
  );

  rrc_round_sat #(.AW(AW), .OW(OW), .SHIFT(SHIFT)) u_rs (
    .acc    (acc),
    .sample (filt)
  );

  always_comb begin
    if (!view[0].live)    byp = '0;
    else if (view[0].neg) byp = -FULL_P;
    else                  byp = FULL_P;
    next_samp = bypass ? byp : filt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      mv_q   <= 1'b0;
      samp_q <= '0;
    end else if (fire) begin
      ph_q   <= (ph_q == LAST_PH) ? '0 : ph_q + 1'b1;
      mv_q   <= 1'b1;
      samp_q <= next_samp;
    end else if (m_ready) begin
      mv_q   <= 1'b0;
    end
  end

  assign m_valid  = mv_q;
  assign m_sample = samp_q;

endmodule

// File: rtl/rrc_interp8_chk.sv
module rrc_interp8_chk #(
  parameter int OW   = 9,
  parameter int FULL = 255
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bypass,
  input logic          burst_en,
  input logic          s_ready,
  input logic          m_valid,
  input logic          m_ready,
  input logic [OW-1:0] m_sample
);

  localparam logic [OW-1:0] LVL_P = OW'(FULL);
  localparam logic [OW-1:0] LVL_N = -OW'(FULL);

  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_sample)); // R6

  AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid); // R6

  AST_READY_NEEDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> burst_en); // R5

  AST_BYPASS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !$past(m_valid && !m_ready) && $past(bypass))
      |-> (m_sample == LVL_P || m_sample == LVL_N || m_sample == '0)); // R4

endmodule

bind rrc_interp8 rrc_interp8_chk #(.OW(OW), .FULL(FULL)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bypass   (bypass),
  .burst_en (burst_en),
  .s_ready  (s_ready),
  .m_valid  (m_valid),
  .m_ready  (m_ready),
  .m_sample (m_sample)
);

// File: tb/rrc_interp8_bench.sv
module rrc_interp8_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bypass = 1'b0, burst_en = 1'b0;
  logic       s_valid = 1'b0, s_sign = 1'b0, m_ready = 1'b0;
  logic       s_ready, m_valid;
  logic [8:0] m_sample;

  int checks = 0, errors = 0;
  bit checking = 0, done = 0;
  string tag_s = "R7", tag_r = "R7";

  // reference model state (updated at posedge)
  int  line [8];
  int  ph = 0;
  bit  mv = 0;
  int  samp = 0;
  bit  took_last = 0;
  bit  seen_hi = 0, seen_lo = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  rrc_interp8 u_rrc_interp8 (
    .clk(clk), .rst_n(rst_n), .bypass(bypass), .burst_en(burst_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_sign(s_sign),
    .m_valid(m_valid), .m_ready(m_ready), .m_sample(m_sample)
  );

  function automatic int coef(int i);
    return (i < 32) ? (i + 1) * 16 : (64 - i) * 16;
  endfunction

  function automatic int filt(int k);
    int acc, r;
    acc = 0;
    for (int n = 0; n < 8; n++) acc += coef(8*n + k) * line[n];
    r = (acc + 4) >>> 3;                      // R3 rounding
    if (r > 255) r = 255;
    if (r < -256) r = -256;
    return r;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model
  always @(posedge clk) begin
    took_last = 0;
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) line[i] = 0;
      ph = 0; mv = 0; samp = 0;
    end else if ((!mv || m_ready) && (ph != 0 || !burst_en || s_valid)) begin
      if (ph == 0) begin
        for (int i = 7; i > 0; i--) line[i] = line[i-1];
        line[0] = burst_en ? (s_sign ? -1 : 1) : 0;
        took_last = burst_en;
      end
      samp = bypass ? line[0] * 255 : filt(ph);
      ph = (ph + 1) % 8;
      mv = 1;
    end else if (m_ready) begin
      mv = 0;
    end
  end

  // compare outputs between edges
  always @(negedge clk) begin
    if (checking) begin
      #1;
      check(tag_r, int'(s_ready), int'((!mv || m_ready) && ph == 0 && burst_en));
      check(tag_s, int'(m_valid), int'(mv));
      if (mv) begin
        check(tag_s, int'($signed(m_sample)), samp);
        if ($signed(m_sample) == 255) seen_hi = 1;
        if ($signed(m_sample) == -256) seen_lo = 1;
      end
    end
  end

  task automatic run(int n, bit rnd_v, bit rnd_r, int mode);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (!s_valid || took_last) begin
        s_valid = rnd_v ? lfsr[0] : 1'b1;
        s_sign  = (mode == 0) ? lfsr[5] : (mode == 2);
      end
      m_ready = rnd_r ? (lfsr[1] | lfsr[2]) : 1'b1;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    #1;
    check("R7", int'(m_valid), 0);
    check("R7", int'(s_ready), 0);
    @(negedge clk);
    rst_n = 1'b1; m_ready = 1'b1;
    checking = 1;
    run(20, 0, 0, 0);                          // R7: idle start gives zeros
    tag_s = "R2"; tag_r = "R1"; burst_en = 1'b1;
    run(400, 0, 0, 0);
    tag_s = "R6"; tag_r = "R8";
    run(600, 1, 1, 0);
    tag_s = "R3"; tag_r = "R1";
    run(120, 0, 0, 2);
    run(120, 0, 0, 1);
    run(120, 1, 1, 2);
    tag_s = "R5"; tag_r = "R5"; burst_en = 1'b0;
    run(100, 0, 0, 0);
    #1 check("R5", int'($signed(m_sample)), 0);
    tag_s = "R4"; tag_r = "R1"; burst_en = 1'b1; bypass = 1'b1;
    run(300, 1, 1, 0);
    burst_en = 1'b0;
    run(40, 0, 0, 0);
    #1 check("R4", int'($signed(m_sample)), 0);
    check("R3", int'(seen_hi), 1);
    check("R3", int'(seen_lo), 1);
    checking = 0;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule